// File: doc/BRIEF.md
# Window Threshold Watchdog Monitor

This block watches converter results as they come out and raises a flag whenever a result falls outside a window set by a programmable low bound and a programmable high bound. Each result comes in as a valid beat. The beat carries the raw, unaligned result, the number of the channel that produced it, and a tag that marks it as a regular or an injected conversion. The window test always uses the raw value. Alignment and offset stages sit downstream and do not affect it.

The monitor can be scoped in two ways. It can guard every channel or just one selected channel. It can also be enabled separately for regular conversions and for injected conversions. When a conversion kind is disabled, results of that kind are not examined at all. A violation sets a sticky flag, which software clears with a write-one-to-clear pulse. The interrupt request is the flag gated by an interrupt enable.

The result input follows valid/ready rules, but the monitor never applies back-pressure. `res_ready` is held high, so every cycle with `res_valid` high delivers one result. Cycles with `res_valid` low carry no result, and their data is ignored. Threshold and configuration pins are plain levels or strobes.

Top module: `wdg_window_mon`

## Requirements
- R1: After reset, `wd_flag` and `wd_irq` are 0, `thr_hi` is all ones (0xFFF) and `thr_lo` is 0.
- R2: When `thr_hi_we` is 1 at a rising edge, `thr_hi` takes `thr_wdata` and `thr_lo` is unchanged. When `thr_lo_we` is 1, `thr_lo` takes `thr_wdata` and `thr_hi` is unchanged. A result sampled on the same edge as a write is compared against the old bound.
- R3: An accepted result in scope whose unsigned raw value is greater than `thr_hi` or less than `thr_lo` sets `wd_flag` at the same rising edge that samples `res_valid`. The flag is therefore visible one clock after the strobe.
- R4: A result exactly equal to `thr_hi` or to `thr_lo` counts as inside the window and does not set the flag.
- R5: `wd_flag` stays 1 until `wd_clr` is 1 at a rising edge, and that edge clears it. If a violation is sampled on the same edge as the clear, the flag stays 1.
- R6: With `res_inj`=0 (regular), a result is examined only when `en_reg`=1. With `res_inj`=1 (injected), a result is examined only when `en_inj`=1. With both enables at 0, the flag never sets.
- R7: With `sel_single`=0, results from all channels are examined. With `sel_single`=1, only results whose `res_chan` equals `sel_chan` are examined, and the same channel applies to both conversion kinds.
- R8: `wd_irq` equals `wd_flag` AND `irq_en`, with no added cycle.
- R9: `res_ready` is always 1 out of reset. Data presented while `res_valid`=0 has no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| thr_hi_we | input | 1 | Load strobe for the high bound |
| thr_lo_we | input | 1 | Load strobe for the low bound |
| thr_wdata | input | RES_W | Bound value to load |
| thr_hi | output | RES_W | Current high bound |
| thr_lo | output | RES_W | Current low bound |
| en_reg | input | 1 | Examine regular results |
| en_inj | input | 1 | Examine injected results |
| sel_single | input | 1 | 1: guard only `sel_chan`; 0: guard all channels |
| sel_chan | input | CH_W | Guarded channel in single mode |
| irq_en | input | 1 | Interrupt enable |
| wd_clr | input | 1 | Write-one-to-clear for the flag |
| res_valid | input | 1 | Result beat valid |
| res_ready | output | 1 | Result beat accepted (always 1) |
| res_data | input | RES_W | Raw unaligned result |
| res_chan | input | CH_W | Channel of the result |
| res_inj | input | 1 | 1: injected conversion; 0: regular |
| wd_flag | output | 1 | Sticky out-of-window flag |
| wd_irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default widths: a 12-bit result and a 5-bit channel number. At these widths the extreme codes 0x000 and 0xFFF can be driven exactly, so a result can be placed on either bound and at the top of the full range. Channel 31, the highest channel number, is reachable in all-channel mode. A single selected channel can be tested against its neighbour and against both conversion kinds.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned RES_W_DEF = 12;
  localparam int unsigned CH_W_DEF  = 5;

  typedef enum logic {
    KIND_REG = 1'b0,
    KIND_INJ = 1'b1
  } conv_kind_e;
endpackage

// File: rtl/wdg_thresh_regs.sv
module wdg_thresh_regs #(
  parameter int unsigned RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_we,
  input  logic             lo_we,
  input  logic [RES_W-1:0] wdata,
  output logic [RES_W-1:0] hi_q,
  output logic [RES_W-1:0] lo_q
);
  localparam logic [RES_W-1:0] HI_RST = {RES_W{1'b1}};
  localparam logic [RES_W-1:0] LO_RST = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= HI_RST;
      lo_q <= LO_RST;
    end else begin
      if (hi_we) hi_q <= wdata;
      if (lo_we) lo_q <= wdata;
    end
  end

  // R2: each bound loads only from its own strobe
  a_r2_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
    hi_we |=> hi_q == $past(wdata));
  a_r2_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_we |=> $stable(hi_q));
  a_r2_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_we |=> $stable(lo_q));
endmodule

// File: rtl/wdg_scope_filter.sv
module wdg_scope_filter #(
  parameter int unsigned CH_W = 5
) (
  input  logic               valid,
  input  logic [CH_W-1:0]    chan,
  input  wdg_pkg::conv_kind_e kind,
  input  logic               en_reg,
  input  logic               en_inj,
  input  logic               single,
  input  logic [CH_W-1:0]    sel_chan,
  output logic               in_scope
);
  logic kind_ok;
  logic chan_ok;

  always_comb begin
    unique case (kind)
      wdg_pkg::KIND_INJ: kind_ok = en_inj;
      default:           kind_ok = en_reg;
    endcase
    chan_ok  = !single || (chan == sel_chan);
    in_scope = valid && kind_ok && chan_ok;
  end
endmodule

// File: rtl/wdg_window_cmp.sv
module wdg_window_cmp #(
  parameter int unsigned RES_W = 12
) (
  input  logic [RES_W-1:0] data,
  input  logic [RES_W-1:0] hi,
  input  logic [RES_W-1:0] lo,
  output logic             outside
);
  logic above;
  logic below;

  always_comb begin
    above   = data > hi;
    below   = data < lo;
    outside = above || below;
  end
endmodule

// File: rtl/wdg_flag_ctrl.sv
module wdg_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag <= 1'b0;
    else if (hit)    flag <= 1'b1;
    else if (clr)    flag <= 1'b0;
  end

  assign irq = flag & irq_en;

  // R3: a qualified violation is visible after the sampling edge
  a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  // R5: flag holds without a clear, and a clear with no new hit drops it
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag);
  // R5: flag only rises after a hit
  a_r5_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit));
endmodule

// File: rtl/wdg_window_mon.sv
module wdg_window_mon #(
  parameter int unsigned RES_W = wdg_pkg::RES_W_DEF,
  parameter int unsigned CH_W  = wdg_pkg::CH_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_hi_we,
  input  logic             thr_lo_we,
  input  logic [RES_W-1:0] thr_wdata,
  output logic [RES_W-1:0] thr_hi,
  output logic [RES_W-1:0] thr_lo,
  input  logic             en_reg,
  input  logic             en_inj,
  input  logic             sel_single,
  input  logic [CH_W-1:0]  sel_chan,
  input  logic             irq_en,
  input  logic             wd_clr,
  input  logic             res_valid,
  output logic             res_ready,
  input  logic [RES_W-1:0] res_data,
  input  logic [CH_W-1:0]  res_chan,
  input  logic             res_inj,
  output logic             wd_flag,
  output logic             wd_irq
);
  logic in_scope;
  logic outside;
  logic hit;
  wdg_pkg::conv_kind_e kind;

  assign kind      = wdg_pkg::conv_kind_e'(res_inj);
  assign res_ready = 1'b1;

  wdg_thresh_regs #(.RES_W(RES_W)) u_thr (
    .clk   (clk),
    .rst_n (rst_n),
    .hi_we (thr_hi_we),
    .lo_we (thr_lo_we),
    .wdata (thr_wdata),
    .hi_q  (thr_hi),
    .lo_q  (thr_lo)
  );

  wdg_scope_filter #(.CH_W(CH_W)) u_scope (
    .valid    (res_valid),
    .chan     (res_chan),
    .kind     (kind),
    .en_reg   (en_reg),
    .en_inj   (en_inj),
    .single   (sel_single),
    .sel_chan (sel_chan),
    .in_scope (in_scope)
  );

  wdg_window_cmp #(.RES_W(RES_W)) u_cmp (
    .data    (res_data),
    .hi      (thr_hi),
    .lo      (thr_lo),
    .outside (outside)
  );

  assign hit = in_scope & outside;

  wdg_flag_ctrl u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit),
    .clr    (wd_clr),
    .irq_en (irq_en),
    .flag   (wd_flag),
    .irq    (wd_irq)
  );

  // R6: no kind enabled means nothing is ever examined
  a_r6_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_reg && !en_inj && !wd_flag) |=> !wd_flag);
  // R7: a foreign channel in single mode cannot raise the flag
  a_r7_foreign: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_single && res_chan != sel_chan && !wd_flag) |=> !wd_flag);
  // R9: an idle beat cannot raise the flag
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && !wd_flag) |=> !wd_flag);
  // R4: a result equal to both bounds is inside
  a_r4_on_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (res_data == thr_hi && res_data == thr_lo && !wd_flag) |=> !wd_flag);
endmodule

// File: tb/wdg_window_mon_tb.sv
module wdg_window_mon_tb_top;
  localparam int RES_W = 12;
  localparam int CH_W  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic thr_hi_we = 0, thr_lo_we = 0;
  logic [RES_W-1:0] thr_wdata = '0;
  logic [RES_W-1:0] thr_hi, thr_lo;
  logic en_reg = 0, en_inj = 0, sel_single = 0, irq_en = 0, wd_clr = 0;
  logic [CH_W-1:0] sel_chan = '0;
  logic res_valid = 0, res_inj = 0;
  logic res_ready;
  logic [RES_W-1:0] res_data = '0;
  logic [CH_W-1:0] res_chan = '0;
  logic wd_flag, wd_irq;

  int n_run = 0;
  int n_fail = 0;
  logic done = 0;

  always #2.5 clk = ~clk;

  wdg_window_mon #(.RES_W(RES_W), .CH_W(CH_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .thr_hi_we(thr_hi_we), .thr_lo_we(thr_lo_we), .thr_wdata(thr_wdata),
    .thr_hi(thr_hi), .thr_lo(thr_lo),
    .en_reg(en_reg), .en_inj(en_inj), .sel_single(sel_single), .sel_chan(sel_chan),
    .irq_en(irq_en), .wd_clr(wd_clr),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_chan(res_chan), .res_inj(res_inj),
    .wd_flag(wd_flag), .wd_irq(wd_irq)
  );

  typedef struct packed {
    logic [11:0] hi;
    logic [11:0] lo;
    logic [11:0] data;
    logic [4:0]  chan;
    logic        inj;
    logic        e_reg;
    logic        e_inj;
    logic        single;
    logic [4:0]  sel;
    logic        exp_flag;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{12'h800, 12'h100, 12'h900, 5'd3,  1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b1}, // R3 above
    '{12'h800, 12'h100, 12'h0FF, 5'd3,  1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b1}, // R3 below
    '{12'h800, 12'h100, 12'h800, 5'd3,  1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0}, // R4 on high
    '{12'h800, 12'h100, 12'h100, 5'd3,  1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0}, // R4 on low
    '{12'h800, 12'h100, 12'h400, 5'd3,  1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0}, // R3 inside
    '{12'h800, 12'h100, 12'h900, 5'd3,  1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0}, // R6 inj off
    '{12'h800, 12'h100, 12'h900, 5'd3,  1'b1, 1'b0, 1'b1, 1'b0, 5'd0, 1'b1}, // R6 inj on
    '{12'h800, 12'h100, 12'h900, 5'd3,  1'b0, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0}, // R6 reg off
    '{12'h800, 12'h100, 12'hFFF, 5'd3,  1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0}, // R6 none
    '{12'h800, 12'h100, 12'h900, 5'd7,  1'b0, 1'b1, 1'b0, 1'b1, 5'd7, 1'b1}, // R7 match
    '{12'h800, 12'h100, 12'h900, 5'd6,  1'b0, 1'b1, 1'b0, 1'b1, 5'd7, 1'b0}, // R7 neighbour
    '{12'h800, 12'h100, 12'h050, 5'd7,  1'b1, 1'b1, 1'b1, 1'b1, 5'd7, 1'b1}, // R7 inj same chan
    '{12'h800, 12'h100, 12'h900, 5'd31, 1'b0, 1'b1, 1'b0, 1'b0, 5'd7, 1'b1}, // R7 all, ch 31
    '{12'hFFF, 12'h000, 12'hFFF, 5'd0,  1'b0, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0}  // R4 full range
  };

  task automatic check(input logic [11:0] act, input logic [11:0] exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic write_bounds(input logic [11:0] hi, input logic [11:0] lo);
    thr_wdata = hi; thr_hi_we = 1; tick;
    thr_hi_we = 0; thr_wdata = lo; thr_lo_we = 1; tick;
    thr_lo_we = 0;
  endtask

  task automatic clear_flag;
    wd_clr = 1; tick; wd_clr = 0;
  endtask

  task automatic send(input logic [11:0] d, input logic [4:0] ch, input logic inj);
    res_data = d; res_chan = ch; res_inj = inj; res_valid = 1; tick;
    res_valid = 0;
  endtask

  initial begin
    repeat (3) tick;
    // R1 reset state
    check(wd_flag, 0, "R1 flag");
    check(wd_irq, 0, "R1 irq");
    check(thr_hi, 12'hFFF, "R1 thr_hi");
    check(thr_lo, 12'h000, "R1 thr_lo");
    rst_n = 1; tick;
    check(res_ready, 1, "R9 ready");
    irq_en = 1;

    for (int i = 0; i < NV; i++) begin
      write_bounds(TBL[i].hi, TBL[i].lo);
      en_reg = TBL[i].e_reg; en_inj = TBL[i].e_inj;
      sel_single = TBL[i].single; sel_chan = TBL[i].sel;
      clear_flag;
      send(TBL[i].data, TBL[i].chan, TBL[i].inj);
      check(wd_flag, TBL[i].exp_flag, $sformatf("R3/R4/R6/R7 vector %0d flag", i));
      check(wd_irq, TBL[i].exp_flag, $sformatf("R8 vector %0d irq", i));
    end

    // R2: separate writes
    write_bounds(12'h700, 12'h200);
    thr_wdata = 12'h6AA; thr_hi_we = 1; tick; thr_hi_we = 0;
    check(thr_hi, 12'h6AA, "R2 hi loaded");
    check(thr_lo, 12'h200, "R2 lo unchanged");
    thr_wdata = 12'h155; thr_lo_we = 1; tick; thr_lo_we = 0;
    check(thr_lo, 12'h155, "R2 lo loaded");
    check(thr_hi, 12'h6AA, "R2 hi unchanged");

    // R2: same-edge write uses old bound (old hi 0x6AA, new 0x800, data 0x700)
    en_reg = 1; en_inj = 0; sel_single = 0; clear_flag;
    thr_wdata = 12'h800; thr_hi_we = 1;
    res_data = 12'h700; res_chan = 0; res_inj = 0; res_valid = 1; tick;
    thr_hi_we = 0; res_valid = 0;
    check(wd_flag, 1, "R2 old bound on same edge");

    // R5 sticky through in-window samples, then clear
    send(12'h400, 5'd0, 1'b0); tick;
    check(wd_flag, 1, "R5 sticky");
    clear_flag;
    check(wd_flag, 0, "R5 cleared");
    // R5 clear and hit same edge
    wd_clr = 1; res_data = 12'hF00; res_valid = 1; tick;
    wd_clr = 0; res_valid = 0;
    check(wd_flag, 1, "R5 hit beats clear");

    // R8 irq gated
    irq_en = 0; #1;
    check(wd_irq, 0, "R8 irq masked");
    irq_en = 1; #1;
    check(wd_irq, 1, "R8 irq unmasked");

    // R9 idle data ignored
    clear_flag;
    res_data = 12'hFFF; res_valid = 0; tick; tick;
    check(wd_flag, 0, "R9 idle ignored");

    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule